// File: doc/BRIEF.md
# In-DRAM Bulk Copy Command Sequencer

This memory-controller block takes one request at a time to copy a DRAM row onto another row, or to clear a row to zero. It turns that request into a stream of activate, precharge and block-transfer commands on a simple command port. The block compares the bank, subarray and row of the source with those of the destination and picks one of three copy modes:

- **Same subarray:** the whole row is copied by two activates with no precharge between them, so the row buffer contents overwrite the destination cells.
- **Different banks:** both rows are opened and the row moves in 64-byte blocks across the internal bus.
- **Same bank, different subarray:** the row passes through a spare per-bank buffer in two phases.

A zero request is handled as a copy whose source is a reserved row in the destination subarray that always reads as zero. A request that names the same row as both source and destination finishes at once and issues no command.

The block holds a busy flag from acceptance to completion. It also shows the destination address that other requesters must stall on while busy is high. Each operation ends with every opened bank precharged. Fixed wait counts, set by parameters, space the commands.

Top module: `bulk_copy_seq`

## Requirements
- R1: A request is taken on a clock edge where `reqValid` and `reqReady` are both high, and `reqReady` is high only while the block is idle. From the next cycle until the cycle of `done` inclusive, `busy` stays high, and `lockBank`/`lockSub`/`lockRow` hold the destination address of the taken request.
- R2: If the source and destination share bank and subarray but differ in row, the commands are:
  - activate the source row;
  - activate the destination row;
  - precharge, carrying the destination address.

  No precharge comes between the two activates.
- R3: If the banks differ, the commands are:
  - activate the source row;
  - activate the destination row;
  - one bank-to-bank transfer per 64-byte block, carrying the source address;
  - precharge the source row;
  - precharge the destination row.
- R4: If the bank is the same but the subarrays differ, the commands are:
  - activate the source row;
  - one to-spare transfer per block, carrying the source address;
  - precharge the source row;
  - activate the destination row;
  - one from-spare transfer per block, carrying the destination address;
  - precharge the destination row.
- R5: A zero request (`reqZero`=1) behaves exactly like a copy whose source is row all-ones of the destination bank and subarray. The source inputs have no effect on it.
- R6: A request whose effective source equals its destination raises `done` in the first cycle after acceptance, and no command is issued.
- R7: Command spacing is fixed by the wait parameters:
  - a command following an activate-to-activate wait comes T_ACT_ACT+1 cycles later;
  - a transfer following an activate comes T_ACT_XFER+1 cycles later;
  - a command following a precharge comes T_PRE+1 cycles later, except that in the different-bank mode the destination precharge follows the source precharge by 1 cycle;
  - consecutive transfers come one per cycle.
- R8: `done` is a one-cycle pulse T_PRE+1 cycles after the last precharge. `reqReady` is high again in the following cycle.
- R9: With the default 8192-byte row and 64-byte block, each transfer run has 128 commands with `cmdBlock` counting 0 to 127 in order. On every transfer, `cmdPeerBank` carries the destination bank. On all other commands, `cmdBlock` and `cmdPeerBank` are 0.
- R10: No command is issued while idle, and when `done` rises, every bank that was activated has been precharged.
- R11: After reset, `busy`, `done` and `cmdValid` are low and `reqReady` is high.
- R12: Command encodings on `cmdOp`: 1 activate, 2 precharge, 3 bank-to-bank transfer, 4 transfer into the spare buffer, 5 transfer out of the spare buffer. Activate and precharge carry the bank, subarray and row they address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle and able to take a request |
| reqZero | input | 1 | 1 = clear destination to zero, 0 = copy |
| reqSrcBank | input | BANK_W | Source bank |
| reqSrcSub | input | SUB_W | Source subarray |
| reqSrcRow | input | ROW_W | Source row within subarray |
| reqDstBank | input | BANK_W | Destination bank |
| reqDstSub | input | SUB_W | Destination subarray |
| reqDstRow | input | ROW_W | Destination row within subarray |
| busy | output | 1 | Operation in flight; stall accesses to the lock address |
| done | output | 1 | One-cycle completion pulse |
| lockBank | output | BANK_W | Destination bank held while busy |
| lockSub | output | SUB_W | Destination subarray held while busy |
| lockRow | output | ROW_W | Destination row held while busy |
| cmdValid | output | 1 | Command present this cycle |
| cmdOp | output | 3 | Command code (see R12) |
| cmdBank | output | BANK_W | Addressed bank |
| cmdSub | output | SUB_W | Addressed subarray |
| cmdRow | output | ROW_W | Addressed row |
| cmdBlock | output | clog2(ROW_BYTES/BLOCK_BYTES) | Block index of a transfer |
| cmdPeerBank | output | BANK_W | Destination bank of a transfer |

## Verification
The assertions assume that request fields are only meaningful in a cycle where `reqValid` and `reqReady` are both high. They also assume that the wait parameters are at least 1, so every wait state lasts at least one cycle. The stimulus drives `reqValid` only after seeing `reqReady` high. It drops `reqValid` right after the accepting edge and then scrambles the request fields while the operation runs, which shows that the block keeps its own copy. Random requests are built per mode, so every class is hit often, including the zero case and the same-row case.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    CMD_NOP             = 3'd0,
    CMD_ACT             = 3'd1,
    CMD_PRE             = 3'd2,
    CMD_XFER_BANK       = 3'd3,
    CMD_XFER_TO_SPARE   = 3'd4,
    CMD_XFER_FROM_SPARE = 3'd5
  } cmdOp_e;

  typedef enum logic [1:0] {
    MODE_SAME_ROW = 2'd0,
    MODE_FPM      = 2'd1,
    MODE_PSM      = 2'd2,
    MODE_SPARE    = 2'd3
  } copyMode_e;

  typedef enum logic [1:0] {
    WAIT_ACT_ACT  = 2'd0,
    WAIT_ACT_XFER = 2'd1,
    WAIT_PRE      = 2'd2
  } waitSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadReq;
    logic     cntLoad;
    waitSel_e waitSel;
    logic     blkClr;
    logic     blkInc;
    cmdOp_e   op;
    logic     useDst;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    copyMode_e reqMode;
    copyMode_e mode;
    logic      cntDone;
    logic      lastBlk;
  } dpStatus_t;

endpackage

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int SUB_W       = 2,
  parameter int ROW_W       = 6,
  parameter int ROW_BYTES   = 8192,
  parameter int BLOCK_BYTES = 64,
  parameter int T_ACT_ACT   = 4,
  parameter int T_ACT_XFER  = 6,
  parameter int T_PRE       = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic                 reqZero,
  input  logic [BANK_W-1:0]    reqSrcBank,
  input  logic [SUB_W-1:0]     reqSrcSub,
  input  logic [ROW_W-1:0]     reqSrcRow,
  input  logic [BANK_W-1:0]    reqDstBank,
  input  logic [SUB_W-1:0]     reqDstSub,
  input  logic [ROW_W-1:0]     reqDstRow,
  output dpStatus_t            status,
  output logic                 cmdValid,
  output logic [2:0]           cmdOp,
  output logic [BANK_W-1:0]    cmdBank,
  output logic [SUB_W-1:0]     cmdSub,
  output logic [ROW_W-1:0]     cmdRow,
  output logic [$clog2(ROW_BYTES/BLOCK_BYTES)-1:0] cmdBlock,
  output logic [BANK_W-1:0]    cmdPeerBank,
  output logic [BANK_W-1:0]    lockBank,
  output logic [SUB_W-1:0]     lockSub,
  output logic [ROW_W-1:0]     lockRow
);

  localparam int BLOCKS   = ROW_BYTES / BLOCK_BYTES;
  localparam int BLK_W    = $clog2(BLOCKS);
  localparam int MAX_AA   = (T_ACT_ACT > T_ACT_XFER) ? T_ACT_ACT : T_ACT_XFER;
  localparam int MAX_WAIT = (MAX_AA > T_PRE) ? MAX_AA : T_PRE;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1) + 1;
  localparam logic [ROW_W-1:0] ZERO_ROW = {ROW_W{1'b1}};

  // effective source: the reserved zero row in the destination subarray
  logic [BANK_W-1:0] effSrcBank;
  logic [SUB_W-1:0]  effSrcSub;
  logic [ROW_W-1:0]  effSrcRow;

  always_comb begin
    effSrcBank = reqZero ? reqDstBank : reqSrcBank;
    effSrcSub  = reqZero ? reqDstSub  : reqSrcSub;
    effSrcRow  = reqZero ? ZERO_ROW   : reqSrcRow;
  end

  // classify the incoming request
  copyMode_e reqMode;
  always_comb begin
    if (effSrcBank != reqDstBank)     reqMode = MODE_PSM;
    else if (effSrcSub != reqDstSub)  reqMode = MODE_SPARE;
    else if (effSrcRow != reqDstRow)  reqMode = MODE_FPM;
    else                              reqMode = MODE_SAME_ROW;
  end

  // captured request
  logic [BANK_W-1:0] srcBankQ, dstBankQ;
  logic [SUB_W-1:0]  srcSubQ,  dstSubQ;
  logic [ROW_W-1:0]  srcRowQ,  dstRowQ;
  copyMode_e         modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcBankQ <= '0;
      srcSubQ  <= '0;
      srcRowQ  <= '0;
      dstBankQ <= '0;
      dstSubQ  <= '0;
      dstRowQ  <= '0;
      modeQ    <= MODE_SAME_ROW;
    end else if (strobe.loadReq) begin
      srcBankQ <= effSrcBank;
      srcSubQ  <= effSrcSub;
      srcRowQ  <= effSrcRow;
      dstBankQ <= reqDstBank;
      dstSubQ  <= reqDstSub;
      dstRowQ  <= reqDstRow;
      modeQ    <= reqMode;
    end
  end

  // wait counter
  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] waitVal;

  always_comb begin
    case (strobe.waitSel)
      WAIT_ACT_ACT:  waitVal = CNT_W'(T_ACT_ACT);
      WAIT_ACT_XFER: waitVal = CNT_W'(T_ACT_XFER);
      default:       waitVal = CNT_W'(T_PRE);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 waitCnt <= '0;
    else if (strobe.cntLoad)   waitCnt <= waitVal;
    else if (waitCnt != '0)    waitCnt <= waitCnt - 1'b1;
  end

  // block index counter
  logic [BLK_W-1:0] blkCnt;

  always_ff @(posedge clk) begin
    if (!rstN)               blkCnt <= '0;
    else if (strobe.blkClr)  blkCnt <= '0;
    else if (strobe.blkInc)  blkCnt <= blkCnt + 1'b1;
  end

  always_comb begin
    status.reqMode = reqMode;
    status.mode    = modeQ;
    status.cntDone = (waitCnt <= CNT_W'(1));
    status.lastBlk = (blkCnt == BLK_W'(BLOCKS - 1));
  end

  // command formatting
  logic isXfer;
  always_comb begin
    isXfer      = (strobe.op == CMD_XFER_BANK) ||
                  (strobe.op == CMD_XFER_TO_SPARE) ||
                  (strobe.op == CMD_XFER_FROM_SPARE);
    cmdValid    = (strobe.op != CMD_NOP);
    cmdOp       = strobe.op;
    cmdBank     = strobe.useDst ? dstBankQ : srcBankQ;
    cmdSub      = strobe.useDst ? dstSubQ  : srcSubQ;
    cmdRow      = strobe.useDst ? dstRowQ  : srcRowQ;
    cmdBlock    = isXfer ? blkCnt   : '0;
    cmdPeerBank = isXfer ? dstBankQ : '0;
    lockBank    = dstBankQ;
    lockSub     = dstSubQ;
    lockRow     = dstRowQ;
  end

endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        reqReady,
  output logic        busy,
  output logic        done
);

  typedef enum logic [3:0] {
    S_IDLE,
    S_ACT_SRC,
    S_WAIT_SRC,
    S_ACT_DST,
    S_WAIT_DST,
    S_XFER,
    S_PRE_SRC,
    S_WAIT_MID,
    S_PRE_DST,
    S_WAIT_END,
    S_FINISH
  } state_e;

  state_e stateQ, stateN;
  logic   phaseQ, phaseN;   // spare mode: 0 = into spare, 1 = out of spare

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      phaseQ <= 1'b0;
    end else begin
      stateQ <= stateN;
      phaseQ <= phaseN;
    end
  end

  always_comb begin
    stateN   = stateQ;
    phaseN   = phaseQ;
    strobe   = '0;
    reqReady = 1'b0;
    done     = 1'b0;
    busy     = (stateQ != S_IDLE);

    case (stateQ)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          phaseN         = 1'b0;
          stateN = (status.reqMode == MODE_SAME_ROW) ? S_FINISH : S_ACT_SRC;
        end
      end

      S_ACT_SRC: begin
        strobe.op      = CMD_ACT;
        strobe.blkClr  = 1'b1;
        strobe.cntLoad = 1'b1;
        strobe.waitSel = (status.mode == MODE_SPARE) ? WAIT_ACT_XFER : WAIT_ACT_ACT;
        stateN         = S_WAIT_SRC;
      end

      S_WAIT_SRC: begin
        if (status.cntDone)
          stateN = (status.mode == MODE_SPARE) ? S_XFER : S_ACT_DST;
      end

      S_ACT_DST: begin
        strobe.op      = CMD_ACT;
        strobe.useDst  = 1'b1;
        strobe.blkClr  = 1'b1;
        strobe.cntLoad = 1'b1;
        strobe.waitSel = (status.mode == MODE_FPM) ? WAIT_ACT_ACT : WAIT_ACT_XFER;
        stateN         = S_WAIT_DST;
      end

      S_WAIT_DST: begin
        if (status.cntDone)
          stateN = (status.mode == MODE_FPM) ? S_PRE_DST : S_XFER;
      end

      S_XFER: begin
        if (status.mode == MODE_PSM)  strobe.op = CMD_XFER_BANK;
        else if (phaseQ)              strobe.op = CMD_XFER_FROM_SPARE;
        else                          strobe.op = CMD_XFER_TO_SPARE;
        strobe.useDst = (status.mode == MODE_SPARE) && phaseQ;
        strobe.blkInc = 1'b1;
        if (status.lastBlk)
          stateN = ((status.mode == MODE_SPARE) && phaseQ) ? S_PRE_DST : S_PRE_SRC;
      end

      S_PRE_SRC: begin
        strobe.op = CMD_PRE;
        if (status.mode == MODE_PSM) begin
          stateN = S_PRE_DST;
        end else begin
          strobe.cntLoad = 1'b1;
          strobe.waitSel = WAIT_PRE;
          stateN         = S_WAIT_MID;
        end
      end

      S_WAIT_MID: begin
        if (status.cntDone) begin
          phaseN = 1'b1;
          stateN = S_ACT_DST;
        end
      end

      S_PRE_DST: begin
        strobe.op      = CMD_PRE;
        strobe.useDst  = 1'b1;
        strobe.cntLoad = 1'b1;
        strobe.waitSel = WAIT_PRE;
        stateN         = S_WAIT_END;
      end

      S_WAIT_END: begin
        if (status.cntDone) stateN = S_FINISH;
      end

      S_FINISH: begin
        done   = 1'b1;
        stateN = S_IDLE;
      end

      default: stateN = S_IDLE;
    endcase
  end

endmodule

// File: rtl/bulk_copy_seq.sv
module bulk_copy_seq
  import bcs_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int SUB_W       = 2,
  parameter int ROW_W       = 6,
  parameter int ROW_BYTES   = 8192,
  parameter int BLOCK_BYTES = 64,
  parameter int T_ACT_ACT   = 4,
  parameter int T_ACT_XFER  = 6,
  parameter int T_PRE       = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqZero,
  input  logic [BANK_W-1:0]    reqSrcBank,
  input  logic [SUB_W-1:0]     reqSrcSub,
  input  logic [ROW_W-1:0]     reqSrcRow,
  input  logic [BANK_W-1:0]    reqDstBank,
  input  logic [SUB_W-1:0]     reqDstSub,
  input  logic [ROW_W-1:0]     reqDstRow,
  output logic                 busy,
  output logic                 done,
  output logic [BANK_W-1:0]    lockBank,
  output logic [SUB_W-1:0]     lockSub,
  output logic [ROW_W-1:0]     lockRow,
  output logic                 cmdValid,
  output logic [2:0]           cmdOp,
  output logic [BANK_W-1:0]    cmdBank,
  output logic [SUB_W-1:0]     cmdSub,
  output logic [ROW_W-1:0]     cmdRow,
  output logic [$clog2(ROW_BYTES/BLOCK_BYTES)-1:0] cmdBlock,
  output logic [BANK_W-1:0]    cmdPeerBank
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  bcs_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .status   (status),
    .strobe   (strobe),
    .reqReady (reqReady),
    .busy     (busy),
    .done     (done)
  );

  bcs_datapath #(
    .BANK_W      (BANK_W),
    .SUB_W       (SUB_W),
    .ROW_W       (ROW_W),
    .ROW_BYTES   (ROW_BYTES),
    .BLOCK_BYTES (BLOCK_BYTES),
    .T_ACT_ACT   (T_ACT_ACT),
    .T_ACT_XFER  (T_ACT_XFER),
    .T_PRE       (T_PRE)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqZero     (reqZero),
    .reqSrcBank  (reqSrcBank),
    .reqSrcSub   (reqSrcSub),
    .reqSrcRow   (reqSrcRow),
    .reqDstBank  (reqDstBank),
    .reqDstSub   (reqDstSub),
    .reqDstRow   (reqDstRow),
    .status      (status),
    .cmdValid    (cmdValid),
    .cmdOp       (cmdOp),
    .cmdBank     (cmdBank),
    .cmdSub      (cmdSub),
    .cmdRow      (cmdRow),
    .cmdBlock    (cmdBlock),
    .cmdPeerBank (cmdPeerBank),
    .lockBank    (lockBank),
    .lockSub     (lockSub),
    .lockRow     (lockRow)
  );

endmodule

// File: rtl/bcs_checks.sv
module bcs_checks
  import bcs_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int SUB_W  = 2,
  parameter int ROW_W  = 6,
  parameter int BLK_W  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqZero,
  input logic [BANK_W-1:0] reqSrcBank,
  input logic [SUB_W-1:0]  reqSrcSub,
  input logic [ROW_W-1:0]  reqSrcRow,
  input logic [BANK_W-1:0] reqDstBank,
  input logic [SUB_W-1:0]  reqDstSub,
  input logic [ROW_W-1:0]  reqDstRow,
  input logic              busy,
  input logic              done,
  input logic [BANK_W-1:0] lockBank,
  input logic [SUB_W-1:0]  lockSub,
  input logic [ROW_W-1:0]  lockRow,
  input logic              cmdValid,
  input logic [2:0]        cmdOp,
  input logic [BLK_W-1:0]  cmdBlock
);

  logic accept;
  logic sameReq;
  logic xferNow;

  always_comb begin
    accept  = reqValid && reqReady;
    sameReq = reqZero ? (reqDstRow == {ROW_W{1'b1}})
                      : ((reqSrcBank == reqDstBank) && (reqSrcSub == reqDstSub) &&
                         (reqSrcRow == reqDstRow));
    xferNow = cmdValid && ((cmdOp == 3'(CMD_XFER_BANK)) ||
                           (cmdOp == 3'(CMD_XFER_TO_SPARE)) ||
                           (cmdOp == 3'(CMD_XFER_FROM_SPARE)));
  end

  // R1: ready only when nothing is in flight
  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busy);

  // R1: an accepted request makes the block busy next cycle
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy);

  // R1: destination lock steady for the whole operation
  a_r1_lock_steady: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(lockBank) && $stable(lockSub) && $stable(lockRow)));

  // R6: same-row request completes in the next cycle without a command
  a_r6_same_row_fast: assert property (@(posedge clk) disable iff (!rstN)
    (accept && sameReq) |=> (done && !cmdValid));

  // R8: done lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done only inside an operation
  a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R9: block index steps by one inside a transfer run
  a_r9_block_step: assert property (@(posedge clk) disable iff (!rstN)
    (xferNow && $past(cmdValid) && ($past(cmdOp) == cmdOp)) |->
      (cmdBlock == BLK_W'($past(cmdBlock) + 1'b1)));

  // R10: no command while idle
  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> busy);

endmodule

bind bulk_copy_seq bcs_checks #(
  .BANK_W (BANK_W),
  .SUB_W  (SUB_W),
  .ROW_W  (ROW_W),
  .BLK_W  ($clog2(ROW_BYTES/BLOCK_BYTES))
) i_checks (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqZero    (reqZero),
  .reqSrcBank (reqSrcBank),
  .reqSrcSub  (reqSrcSub),
  .reqSrcRow  (reqSrcRow),
  .reqDstBank (reqDstBank),
  .reqDstSub  (reqDstSub),
  .reqDstRow  (reqDstRow),
  .busy       (busy),
  .done       (done),
  .lockBank   (lockBank),
  .lockSub    (lockSub),
  .lockRow    (lockRow),
  .cmdValid   (cmdValid),
  .cmdOp      (cmdOp),
  .cmdBlock   (cmdBlock)
);

// File: tb/test_bulk_copy_seq.sv
module test_bulk_copy_seq;

  localparam int CLK_PERIOD  = 10;
  localparam int BANK_W      = 2;
  localparam int SUB_W       = 2;
  localparam int ROW_W       = 6;
  localparam int ROW_BYTES   = 8192;
  localparam int BLOCK_BYTES = 64;
  localparam int T_ACT_ACT   = 4;
  localparam int T_ACT_XFER  = 6;
  localparam int T_PRE       = 5;
  localparam int BLOCKS      = ROW_BYTES / BLOCK_BYTES;
  localparam int BLK_W       = $clog2(BLOCKS);
  localparam int NBANK       = 1 << BANK_W;
  localparam int NSUB        = 1 << SUB_W;
  localparam int NROW        = 1 << ROW_W;
  localparam int ZROW        = NROW - 1;
  localparam int MAXCMD      = 2 * BLOCKS + 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqZero = 1'b0;
  logic [BANK_W-1:0] reqSrcBank = '0;
  logic [SUB_W-1:0]  reqSrcSub = '0;
  logic [ROW_W-1:0]  reqSrcRow = '0;
  logic [BANK_W-1:0] reqDstBank = '0;
  logic [SUB_W-1:0]  reqDstSub = '0;
  logic [ROW_W-1:0]  reqDstRow = '0;
  logic              busy, done;
  logic [BANK_W-1:0] lockBank;
  logic [SUB_W-1:0]  lockSub;
  logic [ROW_W-1:0]  lockRow;
  logic              cmdValid;
  logic [2:0]        cmdOp;
  logic [BANK_W-1:0] cmdBank;
  logic [SUB_W-1:0]  cmdSub;
  logic [ROW_W-1:0]  cmdRow;
  logic [BLK_W-1:0]  cmdBlock;
  logic [BANK_W-1:0] cmdPeerBank;

  bulk_copy_seq #(
    .BANK_W(BANK_W), .SUB_W(SUB_W), .ROW_W(ROW_W),
    .ROW_BYTES(ROW_BYTES), .BLOCK_BYTES(BLOCK_BYTES),
    .T_ACT_ACT(T_ACT_ACT), .T_ACT_XFER(T_ACT_XFER), .T_PRE(T_PRE)
  ) i_bulk_copy_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqZero(reqZero), .reqSrcBank(reqSrcBank), .reqSrcSub(reqSrcSub),
    .reqSrcRow(reqSrcRow), .reqDstBank(reqDstBank), .reqDstSub(reqDstSub),
    .reqDstRow(reqDstRow), .busy(busy), .done(done), .lockBank(lockBank),
    .lockSub(lockSub), .lockRow(lockRow), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBank(cmdBank), .cmdSub(cmdSub), .cmdRow(cmdRow), .cmdBlock(cmdBlock),
    .cmdPeerBank(cmdPeerBank)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cycleCount = 0;
  always @(posedge clk) cycleCount <= cycleCount + 1;

  int tests = 0;
  int fails = 0;

  // expected command list
  int expN;
  int expOp[MAXCMD], expBank[MAXCMD], expSub[MAXCMD], expRow[MAXCMD];
  int expBlk[MAXCMD], expPeer[MAXCMD], expCyc[MAXCMD];
  int expDone;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic addExp(input int op, input int b, input int s, input int r,
                        input int blk, input int peer, input int cyc);
    expOp[expN] = op;  expBank[expN] = b; expSub[expN] = s; expRow[expN] = r;
    expBlk[expN] = blk; expPeer[expN] = peer; expCyc[expN] = cyc;
    expN++;
  endtask

  // expected sequence from R2..R7, R9, R12
  task automatic buildExp(input bit z, input int sb, input int ss, input int sr,
                          input int db, input int ds, input int dr, output string req);
    int eb, es, er, t;
    eb = z ? db : sb;
    es = z ? ds : ss;
    er = z ? ZROW : sr;
    expN = 0;
    t = 0;
    if (eb == db && es == ds && er == dr) begin
      req = "R6";
      expDone = 0;
    end else if (eb == db && es == ds) begin
      req = "R2";
      addExp(1, eb, es, er, 0, 0, t);
      t += T_ACT_ACT + 1; addExp(1, db, ds, dr, 0, 0, t);
      t += T_ACT_ACT + 1; addExp(2, db, ds, dr, 0, 0, t);
      expDone = t + T_PRE + 1;
    end else if (eb != db) begin
      req = "R3";
      addExp(1, eb, es, er, 0, 0, t);
      t += T_ACT_ACT + 1; addExp(1, db, ds, dr, 0, 0, t);
      t += T_ACT_XFER + 1;
      for (int k = 0; k < BLOCKS; k++) begin
        addExp(3, eb, es, er, k, db, t);
        t++;
      end
      addExp(2, eb, es, er, 0, 0, t);
      t++; addExp(2, db, ds, dr, 0, 0, t);
      expDone = t + T_PRE + 1;
    end else begin
      req = "R4";
      addExp(1, eb, es, er, 0, 0, t);
      t += T_ACT_XFER + 1;
      for (int k = 0; k < BLOCKS; k++) begin
        addExp(4, eb, es, er, k, db, t);
        t++;
      end
      addExp(2, eb, es, er, 0, 0, t);
      t += T_PRE + 1; addExp(1, db, ds, dr, 0, 0, t);
      t += T_ACT_XFER + 1;
      for (int k = 0; k < BLOCKS; k++) begin
        addExp(5, db, ds, dr, k, db, t);
        t++;
      end
      addExp(2, db, ds, dr, 0, 0, t);
      expDone = t + T_PRE + 1;
    end
    if (z) req = {req, "/R5"};
  endtask

  task automatic runReq(input bit z, input int sb, input int ss, input int sr,
                        input int db, input int ds, input int dr);
    string req;
    int base, capN, doneAt, openMask, wait0;
    bit busyLost, seqOk;
    int badIdx, badAct, badExp;
    buildExp(z, sb, ss, sr, db, ds, dr, req);

    @(negedge clk);
    wait0 = 0;
    while (!reqReady && wait0 < 1000) begin
      @(negedge clk);
      wait0++;
    end
    check(!cmdValid && reqReady, "R10", "idle command/ready", int'(cmdValid), 0);

    reqZero    = z;
    reqSrcBank = BANK_W'(sb); reqSrcSub = SUB_W'(ss); reqSrcRow = ROW_W'(sr);
    reqDstBank = BANK_W'(db); reqDstSub = SUB_W'(ds); reqDstRow = ROW_W'(dr);
    reqValid   = 1'b1;
    @(negedge clk);
    reqValid   = 1'b0;
    base       = cycleCount;
    // scramble fields: the block must use its own copy
    reqZero    = ~z;
    reqSrcBank = BANK_W'($urandom); reqSrcSub = SUB_W'($urandom); reqSrcRow = ROW_W'($urandom);
    reqDstBank = BANK_W'($urandom); reqDstSub = SUB_W'($urandom); reqDstRow = ROW_W'($urandom);

    check(busy && !reqReady && int'(lockBank) == db && int'(lockSub) == ds && int'(lockRow) == dr,
          "R1", "busy+lock at accept", int'(lockRow), dr);

    capN = 0; doneAt = -1; openMask = 0; busyLost = 0; seqOk = 1;
    badIdx = -1; badAct = 0; badExp = 0;
    for (int k = 0; k < 3000; k++) begin
      if (!busy) busyLost = 1;
      if (cmdValid) begin
        if (capN >= expN) begin
          if (seqOk) begin badIdx = capN; badAct = int'(cmdOp); badExp = 0; end
          seqOk = 0;
        end else if (int'(cmdOp) != expOp[capN] || int'(cmdBank) != expBank[capN] ||
                     int'(cmdSub) != expSub[capN] || int'(cmdRow) != expRow[capN] ||
                     int'(cmdBlock) != expBlk[capN] || int'(cmdPeerBank) != expPeer[capN] ||
                     (cycleCount - base) != expCyc[capN]) begin
          if (seqOk) begin
            badIdx = capN;
            badAct = int'(cmdOp) * 1000 + (cycleCount - base);
            badExp = expOp[capN] * 1000 + expCyc[capN];
          end
          seqOk = 0;
        end
        if (int'(cmdOp) == 1) openMask |= (1 << int'(cmdBank));
        if (int'(cmdOp) == 2) openMask &= ~(1 << int'(cmdBank));
        capN++;
      end
      if (done) begin
        doneAt = cycleCount - base;
        break;
      end
      @(negedge clk);
    end

    if (!seqOk)
      $display("  mismatch at command %0d (value = op*1000+cycle)", badIdx);
    check(seqOk, req, "command op/fields/cycle (R7 R9 R12)", badAct, badExp);
    check(capN == expN, req, "command count", capN, expN);
    check(doneAt == expDone, "R8", "done cycle", doneAt, expDone);
    check(!busyLost, "R1", "busy held through operation", int'(busyLost), 0);
    check(openMask == 0, "R10", "open banks at done", openMask, 0);
    @(negedge clk);
    check(reqReady && !busy && !done, "R8", "ready after done",
          int'({reqReady, busy, done}), 4);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected <190000 cycles", cycleCount);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seedV;
    seedV = $urandom(32'd20411);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(!busy && !done && !cmdValid && reqReady, "R11", "reset outputs",
          int'({busy, done, cmdValid, reqReady}), 1);

    // directed corner cases
    runReq(0, 1, 2, 0, 1, 2, ZROW);     // R2 whole-row copy, row extremes
    runReq(0, 0, 0, 5, 3, 3, 9);        // R3 bank 0 -> 3
    runReq(0, 2, 3, 7, 2, 0, 7);        // R4 same bank, sub 3 -> 0
    runReq(1, 3, 1, 4, 0, 2, 10);       // R5 source fields ignored
    runReq(1, 1, 1, 1, 2, 3, ZROW);     // R5/R6 clearing the zero row itself
    runReq(0, 3, 2, 33, 3, 2, 33);      // R6 same row copy
    runReq(1, 0, 0, 0, 0, 0, 0);        // R5 clear row 0 of bank 0

    // random mix
    for (int i = 0; i < 40; i++) begin
      int kind, sb, ss, sr, db, ds, dr;
      kind = $urandom_range(0, 4);
      sb = $urandom_range(0, NBANK - 1);
      ss = $urandom_range(0, NSUB - 1);
      sr = $urandom_range(0, NROW - 1);
      db = sb; ds = ss; dr = sr;
      case (kind)
        0: dr = (sr + 1 + $urandom_range(0, NROW - 2)) % NROW;
        1: begin
             db = (sb + 1 + $urandom_range(0, NBANK - 2)) % NBANK;
             ds = $urandom_range(0, NSUB - 1);
             dr = $urandom_range(0, NROW - 1);
           end
        2: begin
             ds = (ss + 1 + $urandom_range(0, NSUB - 2)) % NSUB;
             dr = $urandom_range(0, NROW - 1);
           end
        3: begin
             db = $urandom_range(0, NBANK - 1);
             ds = $urandom_range(0, NSUB - 1);
             dr = $urandom_range(0, NROW - 1);
           end
        default: ;
      endcase
      runReq(kind == 3, sb, ss, sr, db, ds, dr);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule